// File: doc/BRIEF.md
# Pulse Width and Period Meter

The block times one digital input in units of a slower base clock. The base clock is the system clock divided by a ratio that software picks. Three candidate lines feed a selector, and the chosen line passes through a two-flop synchronizer and then a digital noise filter. Only filtered level changes count as edges.

Four measurement modes exist. The first three time the high level, the low level, or one full cycle between two rising edges. The fourth times a single low phase and the period that contains it, and completes both in the same pass. A measurement opens at the first qualifying edge after enable or after acknowledge. A closing edge latches the results and raises `done`. The block then ignores the input until `ack` re-arms it. A count that runs past the counter range stops at its maximum and raises `overflow`.

Mode, divider and source are captured only while `run_en` is low, so a configuration holds for the whole enabled session.

Top module: `pulse_gauge`

## Requirements
- R1: After reset, `done` and `overflow` are 0 and both result outputs read 0.
- R2: With mode code 0, `result_a` equals the number of base ticks from a recognised rising edge to the next recognised falling edge, and `result_b` reads 0.
- R3: With mode code 1, `result_a` equals the number of base ticks from a recognised falling edge to the next recognised rising edge, and `result_b` reads 0.
- R4: With mode code 2, `result_a` equals the number of base ticks between two successive recognised rising edges.
- R5: With mode code 3, one pass opens on a falling edge. It then reports the low time up to the following rising edge in `result_b` and the period up to the next falling edge in `result_a`. Both values appear on the same cycle.
- R6: The base tick period is (`div_sel`+1)×DIV_STEP system clocks. With the default DIV_STEP of 1 this spans 1 to 8, and with DIV_STEP of 2 it spans 2 to 16.
- R7: A new input level is recognised only after FILT_LEN consecutive base-tick samples agree (default 3). A shorter excursion has no effect on the result, and a pulse of exactly FILT_LEN ticks is measured.
- R8: `src_sel` codes 0, 1 and 2 pick `in_lines[0]`, `in_lines[1]` and `in_lines[2]`, and code 3 picks `in_lines[0]`. Activity on the other lines has no effect.
- R9: An interval already in progress when enable rises is discarded, and measurement begins at the first opening edge seen after enable.
- R10: The count saturates at 2^CNT_W−1. If a tick would carry it past that value, including the closing tick, `overflow` is set and the result reads the maximum.
- R11: While `done` is high, the results stay fixed and input edges are ignored. A cycle with `ack` high clears `done` and `overflow` and waits for a fresh opening edge.
- R12: Driving `run_en` low clears `done` and `overflow` on the next clock. Mode, divider and source inputs take effect only while `run_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Enables measurement; low reloads configuration |
| mode_sel | input | 2 | 0 high width, 1 low width, 2 period, 3 low width plus period |
| div_sel | input | DIV_SEL_W | Base clock ratio select |
| src_sel | input | SRC_W | Input line select |
| in_lines | input | N_SRC | Candidate input lines |
| ack | input | 1 | Clears the completion flag and re-arms |
| result_a | output | CNT_W | Main result (width or period) |
| result_b | output | CNT_W | Low width in mode 3, else 0 |
| done | output | 1 | Measurement complete |
| overflow | output | 1 | Count reached saturation |

## Verification
The closing edge and counter saturation can fall on the same base tick. The bench provokes this with high pulses of exactly 65535 and 65536 ticks at ratio 1. The first must report 65535 with `overflow` clear. The second must report 65535 with `overflow` set, because saturation and the closing edge coincide. A sweep over every divider ratio, every mode and all source codes compares each result with widths the bench computes from its own stimulus.

// File: rtl/pulse_gauge_pkg.sv
package pulse_gauge_pkg;

  typedef enum logic [1:0] {
    PG_HIGH   = 2'd0,
    PG_LOW    = 2'd1,
    PG_PERIOD = 2'd2,
    PG_DUAL   = 2'd3
  } pg_mode_e;

  typedef enum logic [1:0] {
    PG_IDLE,
    PG_ARM,
    PG_COUNT,
    PG_HOLD
  } pg_state_e;

  // base tick period in system clocks for a given select code
  function automatic int unsigned base_ratio(input int unsigned sel, input int unsigned step);
    return (sel + 1) * step;
  endfunction

  function automatic logic opens_on_rise(input pg_mode_e m);
    return (m == PG_HIGH) || (m == PG_PERIOD);
  endfunction

  function automatic logic closes_on_rise(input pg_mode_e m);
    return (m == PG_LOW) || (m == PG_PERIOD);
  endfunction

endpackage

// File: rtl/pulse_gauge_div.sv
module pulse_gauge_div
  import pulse_gauge_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int STEP  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int MAXR = (2 ** SEL_W) * STEP;
  localparam int CW   = $clog2(MAXR + 1);

  logic [CW-1:0] phase_q;
  logic [CW-1:0] limit;

  always_comb limit = CW'(base_ratio(32'(sel), STEP) - 1);

  assign tick = en && (phase_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            phase_q <= '0;
    else if (!en || tick)  phase_q <= '0;
    else                   phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/pulse_gauge_front.sv
module pulse_gauge_front #(
  parameter int N_SRC    = 3,
  parameter int SRC_W    = 2,
  parameter int FILT_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [SRC_W-1:0] src_sel,
  input  logic [N_SRC-1:0] lines,
  output logic             level,
  output logic             rise_evt,
  output logic             fall_evt
);
  localparam int RW = $clog2(FILT_LEN + 1);
  localparam logic [RW-1:0] RUN_FULL = RW'(FILT_LEN);

  logic          picked;
  logic [1:0]    sync_q;
  logic          sampled;
  logic          cand_q;
  logic          lvl_q;
  logic [RW-1:0] run_q;
  logic [RW-1:0] run_nx;
  logic          qualify;

  // unassigned select codes fall back to line 0
  always_comb begin
    picked = lines[0];
    for (int i = 0; i < N_SRC; i++)
      if (src_sel == SRC_W'(i)) picked = lines[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], picked};
  end
  assign sampled = sync_q[1];

  always_comb begin
    if (sampled != cand_q)     run_nx = RW'(1);
    else if (run_q == RUN_FULL) run_nx = run_q;
    else                        run_nx = run_q + 1'b1;
  end

  assign qualify  = tick && (run_nx == RUN_FULL) && (sampled != lvl_q);
  assign rise_evt = qualify && sampled;
  assign fall_evt = qualify && !sampled;
  assign level    = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= 1'b0;
      lvl_q  <= 1'b0;
      run_q  <= '0;
    end else if (!en) begin
      cand_q <= sampled;
      lvl_q  <= sampled;
      run_q  <= RUN_FULL;
    end else if (tick) begin
      cand_q <= sampled;
      run_q  <= run_nx;
      if (qualify) lvl_q <= sampled;
    end
  end
endmodule

// File: rtl/pulse_gauge_core.sv
module pulse_gauge_core
  import pulse_gauge_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             rise_evt,
  input  logic             fall_evt,
  input  pg_mode_e         mode,
  input  logic             ack,
  output logic [CNT_W-1:0] result_a,
  output logic [CNT_W-1:0] result_b,
  output logic             done,
  output logic             overflow,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CMAX) ? v : v + 1'b1;
  endfunction

  pg_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] stage_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             at_max;
  logic             open_evt;
  logic             close_evt;
  logic             mid_evt;

  assign cnt_inc   = sat_inc(cnt_q);
  assign at_max    = (cnt_q == CMAX);
  assign open_evt  = tick && (opens_on_rise(mode)  ? rise_evt : fall_evt);
  assign close_evt = tick && (closes_on_rise(mode) ? rise_evt : fall_evt);
  assign mid_evt   = tick && (mode == PG_DUAL) && rise_evt;
  assign count_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PG_IDLE;
      cnt_q    <= '0;
      stage_q  <= '0;
      result_a <= '0;
      result_b <= '0;
      done     <= 1'b0;
      overflow <= 1'b0;
    end else if (!en) begin
      st_q     <= PG_IDLE;
      cnt_q    <= '0;
      stage_q  <= '0;
      done     <= 1'b0;
      overflow <= 1'b0;
    end else begin
      case (st_q)
        PG_IDLE: st_q <= PG_ARM;
        PG_ARM: begin
          if (open_evt) begin
            cnt_q   <= '0;
            stage_q <= '0;
            st_q    <= PG_COUNT;
          end
        end
        PG_COUNT: begin
          if (close_evt) begin
            result_a <= cnt_inc;
            result_b <= (mode == PG_DUAL) ? stage_q : '0;
            if (at_max) overflow <= 1'b1;
            done <= 1'b1;
            st_q <= PG_HOLD;
          end else if (tick) begin
            cnt_q <= cnt_inc;
            if (at_max)  overflow <= 1'b1;
            if (mid_evt) stage_q  <= cnt_inc;
          end
        end
        PG_HOLD: begin
          if (ack) begin
            done     <= 1'b0;
            overflow <= 1'b0;
            st_q     <= PG_ARM;
          end
        end
        default: st_q <= PG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pulse_gauge.sv
module pulse_gauge
  import pulse_gauge_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int DIV_SEL_W = 3,
  parameter int DIV_STEP  = 1,
  parameter int FILT_LEN  = 3,
  parameter int N_SRC     = 3,
  parameter int SRC_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_en,
  input  logic [1:0]           mode_sel,
  input  logic [DIV_SEL_W-1:0] div_sel,
  input  logic [SRC_W-1:0]     src_sel,
  input  logic [N_SRC-1:0]     in_lines,
  input  logic                 ack,
  output logic [CNT_W-1:0]     result_a,
  output logic [CNT_W-1:0]     result_b,
  output logic                 done,
  output logic                 overflow
);
  pg_mode_e             cfg_mode;
  logic [DIV_SEL_W-1:0] cfg_div;
  logic [SRC_W-1:0]     cfg_src;
  logic [1:0]           cfg_mode_bits;
  logic                 base_tick;
  logic                 filt_level;
  logic                 rise_evt;
  logic                 fall_evt;
  logic [CNT_W-1:0]     count_q;

  // configuration is only taken while the block is disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_mode <= PG_HIGH;
      cfg_div  <= '0;
      cfg_src  <= '0;
    end else if (!run_en) begin
      cfg_mode <= pg_mode_e'(mode_sel);
      cfg_div  <= div_sel;
      cfg_src  <= src_sel;
    end
  end
  assign cfg_mode_bits = cfg_mode;

  pulse_gauge_div #(.SEL_W(DIV_SEL_W), .STEP(DIV_STEP)) u_div (
    .clk(clk), .rst_n(rst_n), .en(run_en), .sel(cfg_div), .tick(base_tick)
  );

  pulse_gauge_front #(.N_SRC(N_SRC), .SRC_W(SRC_W), .FILT_LEN(FILT_LEN)) u_front (
    .clk(clk), .rst_n(rst_n), .en(run_en), .tick(base_tick),
    .src_sel(cfg_src), .lines(in_lines),
    .level(filt_level), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  pulse_gauge_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .en(run_en), .tick(base_tick),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .mode(cfg_mode), .ack(ack),
    .result_a(result_a), .result_b(result_b), .done(done),
    .overflow(overflow), .count_o(count_q)
  );
endmodule

// File: rtl/pulse_gauge_chk.sv
module pulse_gauge_chk
  import pulse_gauge_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int FILT_LEN = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             ack,
  input logic             done,
  input logic             overflow,
  input logic [CNT_W-1:0] result_a,
  input logic [CNT_W-1:0] result_b,
  input logic             tick,
  input logic             rise_evt,
  input logic             fall_evt,
  input logic             level,
  input logic [CNT_W-1:0] cnt_q,
  input logic [1:0]       cfg_mode
);
  localparam logic [CNT_W-1:0] CMAX  = '1;
  localparam logic [CNT_W-1:0] FMIN  = CNT_W'(FILT_LEN);
  localparam logic [CNT_W-1:0] FMIN2 = CNT_W'(2 * FILT_LEN);

  AST_EDGES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_evt, fall_evt}));  // R7
  AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt || fall_evt) |-> tick);  // R6
  AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> !level);  // R7
  AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && (cfg_mode == PG_HIGH || cfg_mode == PG_LOW) |-> result_a >= FMIN);  // R7
  AST_MIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && (cfg_mode == PG_PERIOD || cfg_mode == PG_DUAL) |-> result_a >= FMIN2);  // R4
  AST_DUAL_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && cfg_mode == PG_DUAL && !overflow |-> result_b >= FMIN && result_b < result_a);  // R5
  AST_SINGLE_B_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && cfg_mode != PG_DUAL |-> result_b == '0);  // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    done && run_en && !ack |=> done && $stable(result_a) && $stable(result_b));  // R11
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    done && run_en && ack |=> !done && !overflow);  // R11
  AST_OVF_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(cnt_q) == CMAX);  // R10
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !done && !overflow);  // R12
endmodule

bind pulse_gauge pulse_gauge_chk #(.CNT_W(CNT_W), .FILT_LEN(FILT_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .ack(ack), .done(done),
  .overflow(overflow), .result_a(result_a), .result_b(result_b),
  .tick(base_tick), .rise_evt(rise_evt), .fall_evt(fall_evt),
  .level(filt_level), .cnt_q(count_q), .cfg_mode(cfg_mode_bits)
);

// File: tb/pulse_gauge_test.sv
module pulse_gauge_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 198000;
  localparam int MD_HIGH = 0, MD_LOW = 1, MD_PERIOD = 2, MD_DUAL = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic [1:0]  mode_sel = '0;
  logic [2:0]  div_sel = '0;
  logic [1:0]  src_sel = '0;
  logic [2:0]  in_lines = '0;
  logic        ack = 1'b0;
  logic [15:0] result_a;
  logic [15:0] result_b;
  logic        done;
  logic        overflow;

  int n_checks = 0;
  int n_fail   = 0;
  int line_idx = 0;
  bit finished = 0;

  pulse_gauge uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_sel(mode_sel),
    .div_sel(div_sel), .src_sel(src_sel), .in_lines(in_lines), .ack(ack),
    .result_a(result_a), .result_b(result_b), .done(done), .overflow(overflow)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // selected line at lvl, all other lines at the opposite level
  task automatic seg(input logic lvl, input int n);
    for (int i = 0; i < 3; i++) in_lines[i] = (i == line_idx) ? lvl : ~lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic configure(input int md, input int dv, input int sr, input logic idle);
    run_en   = 1'b0;
    ack      = 1'b0;
    mode_sel = 2'(md);
    div_sel  = 3'(dv);
    src_sel  = 2'(sr);
    line_idx = (sr == 3) ? 0 : sr;
    seg(idle, 6);
    run_en = 1'b1;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic check_result(input string tag, input int ea, input int eb, input int eo);
    check(tag, "done", int'(done), 1);
    check(tag, "result_a", int'(result_a), ea);
    check(tag, "result_b", int'(result_b), eb);
    check(tag, "overflow", int'(overflow), eo);
  endtask

  task automatic run_case(input string tag, input int md, input int dv, input int sr,
                          input int w1, input int w2, input int ea, input int eb);
    int r;
    logic s;
    r = dv + 1;
    s = (md == MD_HIGH || md == MD_PERIOD) ? 1'b0 : 1'b1;
    configure(md, dv, sr, s);
    seg(s, 6 * r);
    seg(~s, w1 * r);
    seg(s, w2 * r);
    seg(~s, w1 * r);
    seg(s, 8 * r + 10);
    check_result(tag, ea, eb, 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYCLES, 0);
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", "done", int'(done), 0);
    check("R1", "overflow", int'(overflow), 0);
    check("R1", "result_a", int'(result_a), 0);
    check("R1", "result_b", int'(result_b), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep every ratio and mode; source code cycles through 0..3 (R6 R8)
    for (int d = 0; d < 8; d++) begin
      run_case("R2 R6 R8", MD_HIGH, d, d % 4, 3 + d, 4, 3 + d, 0);
      run_case("R3 R6 R8", MD_LOW, d, (d + 1) % 4, 3 + (d % 3), 5, 3 + (d % 3), 0);
      run_case("R4 R6 R8", MD_PERIOD, d, (d + 2) % 4, 4, 3 + d, 7 + d, 0);
      run_case("R5 R6 R8", MD_DUAL, d, (d + 3) % 4, 3 + d, 5, 8 + d, 3 + d);
    end

    // R9: enable in the middle of a high phase; that partial pulse is dropped
    configure(MD_HIGH, 0, 0, 1'b1);
    seg(1'b1, 7);
    seg(1'b0, 10);
    seg(1'b1, 15);
    seg(1'b0, 20);
    check_result("R9", 15, 0, 0);

    // R7: 2-tick pulse ignored, 2-tick low glitch inside a pulse ignored
    configure(MD_HIGH, 0, 1, 1'b0);
    seg(1'b0, 10);
    seg(1'b1, 2);
    seg(1'b0, 10);
    seg(1'b1, 12);
    seg(1'b0, 2);
    seg(1'b1, 12);
    seg(1'b0, 20);
    check_result("R7", 26, 0, 0);

    // R11: further pulses while done are ignored
    seg(1'b1, 5);
    seg(1'b0, 5);
    seg(1'b1, 9);
    seg(1'b0, 9);
    check("R11", "done held", int'(done), 1);
    check("R11", "result held", int'(result_a), 26);
    pulse_ack();
    check("R11", "done after ack", int'(done), 0);
    seg(1'b0, 5);
    seg(1'b1, 9);
    seg(1'b0, 20);
    check_result("R11", 9, 0, 0);

    // R12: mode input changed while enabled has no effect
    pulse_ack();
    mode_sel = 2'(MD_LOW);
    seg(1'b0, 5);
    seg(1'b1, 11);
    seg(1'b0, 20);
    check_result("R12", 11, 0, 0);
    run_en = 1'b0;
    @(negedge clk);
    check("R12", "done after disable", int'(done), 0);

    // R10: widths at and just past the counter range
    configure(MD_HIGH, 0, 2, 1'b0);
    seg(1'b0, 6);
    seg(1'b1, 65535);
    seg(1'b0, 12);
    check_result("R10", 65535, 0, 0);
    pulse_ack();
    seg(1'b0, 4);
    seg(1'b1, 65536);
    seg(1'b0, 12);
    check_result("R10", 65535, 0, 1);
    pulse_ack();
    check("R10", "overflow after ack", int'(overflow), 0);

    finish_up();
  end
endmodule